// File: doc/BRIEF.md
# Register-Mapped Integer Divider

This block divides two 32-bit integers over many clock cycles. Software reaches it through a small synchronous register bus. It holds a dividend, a divisor, a quotient, a remainder and a status word. The dividend and the divisor each appear at two addresses. One address treats the operand as unsigned and the other treats it as two's complement. Whichever of these addresses is written last sets the signedness of the next calculation.

Any write to an operand address starts a fresh radix-2 restoring division with the operands as they stand after that write. The calculation takes a fixed 32 steps, and status bit READY stays low for all of them. When the result lands, READY rises and the quotient and remainder can be read.

Both result registers are writable. An interrupted context can therefore be put back without any computation: writing a result loads the value as it is and leaves the unit idle. A DIRTY flag tells a context-switch handler that the unit has been touched since the quotient was last collected.

Top module: `mmdiv`

## Requirements
- R1: After reset the quotient and remainder read 0. The status word reads 1, with READY in bit 0 set and DIRTY in bit 1 clear.
- R2: Addresses are 0 unsigned dividend, 1 unsigned divisor, 2 signed dividend, 3 signed divisor, 4 quotient, 5 remainder and 6 status. Read data appears on `bus_rdata` one cycle after the read strobe. Both aliases of an operand read back the stored value, and address 7 reads 0.
- R3: A write to any operand address starts a calculation. Status reads taken in the 32 cycles that follow the write show READY = 0, and the next one shows READY = 1.
- R4: With unsigned operands the quotient is the floor of dividend/divisor and the remainder is dividend minus quotient times divisor.
- R5: With signed operands the quotient truncates toward zero and the remainder carries the sign of the dividend. Dividing -2^31 by -1 gives a quotient of 0x80000000 and a remainder of 0.
- R6: Division by zero returns the dividend as the remainder. The quotient is 0xFFFFFFFF for unsigned operands. For signed operands it is -1 for a non-negative dividend and +1 for a negative one.
- R7: Writing any of addresses 0 to 5 sets DIRTY. Reading the quotient clears DIRTY. Reading the remainder leaves it unchanged.
- R8: Writing the quotient or the remainder stores that value and sets READY at once. A calculation still in flight is abandoned and never overwrites either result.
- R9: The status word is read-only. Writing address 6 changes neither READY nor DIRTY.
- R10: An operand write during a calculation restarts it with the updated operands and a full 32-cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
Several internal faults show up at the ports. A wrong step counter makes READY rise before or after the 33rd status read that follows a start. A sign fix-up that is wrong or latched at the wrong time corrupts the quotient or remainder as soon as READY returns. A calculation that is not abandoned when a result is loaded overwrites the loaded value about 32 cycles later, which a later read exposes. A DIRTY flag that is stuck or clears at the wrong moment appears on the status read that immediately follows the access that should have set or cleared it.

// File: rtl/mmdiv_pkg.sv
package mmdiv_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_UDIVIDEND = 3'd0,
    A_UDIVISOR  = 3'd1,
    A_SDIVIDEND = 3'd2,
    A_SDIVISOR  = 3'd3,
    A_QUOT      = 3'd4,
    A_REM       = 3'd5,
    A_STATUS    = 3'd6
  } reg_addr_e;

  localparam int ST_READY_BIT = 0;
  localparam int ST_DIRTY_BIT = 1;
endpackage

// File: rtl/mmdiv_step.sv
// One restoring shift-subtract iteration on magnitudes.
module mmdiv_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] q_o
);
  logic [W:0] shifted;
  logic [W:0] diff;

  always_comb begin
    shifted = {acc_i, q_i[W-1]};
    diff    = shifted - {1'b0, dvs_i};
    acc_o   = diff[W] ? shifted[W-1:0] : diff[W-1:0];
    q_o     = {q_i[W-2:0], ~diff[W]};
  end
endmodule

// File: rtl/mmdiv_core.sv
// Iterative divider: loads magnitudes on start, runs W steps, applies sign fix-up.
module mmdiv_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         abort,
  input  logic         is_signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     acc_q, qsh_q, dvs_q;
  logic [W-1:0]     acc_n, qsh_n;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, neg_q_q, neg_r_q;

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] x, input logic s);
    return (s && x[W-1]) ? (~x + W'(1)) : x;
  endfunction

  mmdiv_step #(.W(W)) u_step (
    .acc_i (acc_q),
    .q_i   (qsh_q),
    .dvs_i (dvs_q),
    .acc_o (acc_n),
    .q_o   (qsh_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      qsh_q   <= '0;
      dvs_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
    end else if (start) begin
      acc_q   <= '0;
      qsh_q   <= magnitude(dividend_i, is_signed_i);
      dvs_q   <= magnitude(divisor_i, is_signed_i);
      cnt_q   <= '0;
      busy_q  <= 1'b1;
      neg_q_q <= is_signed_i && (dividend_i[W-1] ^ divisor_i[W-1]);
      neg_r_q <= is_signed_i && dividend_i[W-1];
    end else if (abort) begin
      busy_q  <= 1'b0;
    end else if (busy_q) begin
      acc_q   <= acc_n;
      qsh_q   <= qsh_n;
      cnt_q   <= cnt_q + CNT_W'(1);
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == LAST) && !start && !abort;
  assign quo_o  = neg_q_q ? -qsh_n : qsh_n;
  assign rem_o  = neg_r_q ? -acc_n : acc_n;
endmodule

// File: rtl/mmdiv.sv
// Register-mapped divider top: register file, alias decode, read mux.
module mmdiv
  import mmdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata
);
  logic [W-1:0] dividend_q, divisor_q, quot_q, rem_q;
  logic [W-1:0] dividend_nx, divisor_nx;
  logic [W-1:0] core_quo, core_rem, rd_sel;
  logic         dirty_q, core_busy, core_done;
  logic         wr_dividend, wr_divisor, wr_signed, op_start;
  logic         wr_quot, wr_rem, res_load, reg_write;

  always_comb begin
    wr_dividend = bus_wr && (bus_addr == A_UDIVIDEND || bus_addr == A_SDIVIDEND);
    wr_divisor  = bus_wr && (bus_addr == A_UDIVISOR  || bus_addr == A_SDIVISOR);
    wr_signed   = (bus_addr == A_SDIVIDEND) || (bus_addr == A_SDIVISOR);
    op_start    = wr_dividend || wr_divisor;
    wr_quot     = bus_wr && (bus_addr == A_QUOT);
    wr_rem      = bus_wr && (bus_addr == A_REM);
    res_load    = wr_quot || wr_rem;
    reg_write   = op_start || res_load;
    dividend_nx = wr_dividend ? bus_wdata : dividend_q;
    divisor_nx  = wr_divisor  ? bus_wdata : divisor_q;
  end

  mmdiv_core #(.W(W)) u_core (
    .clk         (clk),
    .rst         (rst),
    .start       (op_start),
    .abort       (res_load),
    .is_signed_i (wr_signed),
    .dividend_i  (dividend_nx),
    .divisor_i   (divisor_nx),
    .busy_o      (core_busy),
    .done_o      (core_done),
    .quo_o       (core_quo),
    .rem_o       (core_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dividend_q <= '0;
      divisor_q  <= '0;
      quot_q     <= '0;
      rem_q      <= '0;
      dirty_q    <= 1'b0;
    end else begin
      dividend_q <= dividend_nx;
      divisor_q  <= divisor_nx;
      if (wr_quot)        quot_q <= bus_wdata;
      else if (core_done) quot_q <= core_quo;
      if (wr_rem)         rem_q  <= bus_wdata;
      else if (core_done) rem_q  <= core_rem;
      if (reg_write)                             dirty_q <= 1'b1;
      else if (bus_rd && bus_addr == A_QUOT)     dirty_q <= 1'b0;
    end
  end

  always_comb begin
    rd_sel = '0;
    case (bus_addr)
      A_UDIVIDEND, A_SDIVIDEND: rd_sel = dividend_q;
      A_UDIVISOR,  A_SDIVISOR:  rd_sel = divisor_q;
      A_QUOT:                   rd_sel = quot_q;
      A_REM:                    rd_sel = rem_q;
      A_STATUS: begin
        rd_sel[ST_READY_BIT] = ~core_busy;
        rd_sel[ST_DIRTY_BIT] = dirty_q;
      end
      default:                  rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_sel;
  end
endmodule

// File: rtl/mmdiv_chk.sv
module mmdiv_chk
  import mmdiv_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic              busy,
  input logic              dirty,
  input logic [W-1:0]      quot
);
  localparam int RL_W = $clog2(W) + 2;
  logic [RL_W-1:0] run_len;
  logic            op_wr;

  assign op_wr = bus_wr && (bus_addr <= 3'd3);

  always_ff @(posedge clk) begin
    if (rst)        run_len <= '0;
    else if (op_wr) run_len <= '0;
    else if (busy)  run_len <= run_len + RL_W'(1);
    else            run_len <= '0;
  end

  p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
    op_wr |=> busy);

  p_busy_window_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_len < RL_W'(W)));

  p_busy_full_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && !bus_wr && run_len < RL_W'(W - 1)) |=> busy);

  p_load_quot_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_QUOT) |=> (!busy && quot == $past(bus_wdata)));

  p_dirty_set_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr <= 3'd5) |=> dirty);

  p_dirty_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == A_QUOT) |=> !dirty);

  p_status_ro_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_STATUS && !busy) |=> (!busy && dirty == $past(dirty)));

  p_status_read_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_STATUS) |=>
      (bus_rdata[ST_READY_BIT] == !$past(busy) && bus_rdata[ST_DIRTY_BIT] == $past(dirty)));
endmodule

bind mmdiv mmdiv_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .busy      (core_busy),
  .dirty     (dirty_q),
  .quot      (quot_q)
);

// File: tb/mmdiv_test.sv
`timescale 1ns/1ps
module mmdiv_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  int total = 0;
  int bad = 0;

  localparam logic [2:0] UDVD = 3'd0, UDVS = 3'd1, SDVD = 3'd2, SDVS = 3'd3;
  localparam logic [2:0] QUO = 3'd4, REMA = 3'd5, STAT = 3'd6;

  always #5 clk = ~clk;

  mmdiv uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic wait_ready();
    logic [31:0] v;
    for (int i = 0; i < 100; i++) begin
      rd(STAT, v);
      if (v[0]) break;
    end
  endtask

  task automatic count_busy(output int zeros);
    logic [31:0] v;
    zeros = 0;
    for (int i = 0; i < 40; i++) begin
      rd(STAT, v);
      if (v[0]) break;
      zeros++;
    end
  endtask

  task automatic run_div(input string req, input bit sgn, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] eq, input logic [31:0] er);
    logic [31:0] v;
    wr(sgn ? SDVS : UDVS, b);
    wr(sgn ? SDVD : UDVD, a);
    wait_ready();
    rd(QUO, v);  check({req, " quotient"}, v, eq);
    rd(REMA, v); check({req, " remainder"}, v, er);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(QUO, v);  check("R1 quotient", v, 32'd0);
    rd(REMA, v); check("R1 remainder", v, 32'd0);
    rd(STAT, v); check("R1 status", v, 32'd1);
  endtask

  task automatic t_timing();
    int z;
    logic [31:0] v;
    wr(UDVS, 32'd7);
    wait_ready();
    wr(UDVD, 32'd100);
    count_busy(z);
    check("R3 busy cycles", 32'(z), 32'd32);
    rd(QUO, v); check("R3 quotient", v, 32'd14);
  endtask

  task automatic t_restart();
    int z;
    logic [31:0] v;
    wr(UDVD, 32'd100);
    repeat (10) @(negedge clk);
    wr(UDVD, 32'd200);
    count_busy(z);
    check("R10 busy after restart", 32'(z), 32'd32);
    rd(QUO, v);  check("R10 quotient", v, 32'd28);
    rd(REMA, v); check("R10 remainder", v, 32'd4);
  endtask

  task automatic t_unsigned();
    run_div("R4 small", 1'b0, 32'd1000, 32'd33, 32'd30, 32'd10);
    run_div("R4 big", 1'b0, 32'hFFFF_FFFF, 32'd16, 32'h0FFF_FFFF, 32'd15);
    run_div("R4 high bit", 1'b0, 32'h8000_0001, 32'h8000_0000, 32'd1, 32'd1);
    run_div("R4 less", 1'b0, 32'd5, 32'd9, 32'd0, 32'd5);
  endtask

  task automatic t_signed();
    run_div("R5 neg/pos", 1'b1, -32'sd7, 32'sd2, -32'sd3, -32'sd1);
    run_div("R5 pos/neg", 1'b1, 32'sd7, -32'sd2, -32'sd3, 32'sd1);
    run_div("R5 neg/neg", 1'b1, -32'sd7, -32'sd2, 32'sd3, -32'sd1);
    run_div("R5 min/-1", 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'd0);
  endtask

  task automatic t_divzero();
    run_div("R6 unsigned", 1'b0, 32'd1234, 32'd0, 32'hFFFF_FFFF, 32'd1234);
    run_div("R6 signed pos", 1'b1, 32'd55, 32'd0, 32'hFFFF_FFFF, 32'd55);
    run_div("R6 signed neg", 1'b1, -32'sd55, 32'd0, 32'd1, -32'sd55);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(UDVS, 32'h0000_0003);
    wr(SDVD, 32'hDEAD_0001);
    wait_ready();
    rd(UDVD, v); check("R2 dividend via unsigned alias", v, 32'hDEAD_0001);
    rd(SDVS, v); check("R2 divisor via signed alias", v, 32'h0000_0003);
    rd(3'd7, v); check("R2 unmapped", v, 32'd0);
  endtask

  task automatic t_dirty();
    logic [31:0] v;
    rd(QUO, v);
    rd(STAT, v); check("R7 cleared by quotient read", v, 32'd1);
    wr(REMA, 32'd9);
    rd(STAT, v); check("R7 set by remainder write", v, 32'd3);
    rd(REMA, v);
    rd(STAT, v); check("R7 remainder read keeps dirty", v, 32'd3);
    rd(QUO, v);
  endtask

  task automatic t_csr_ro();
    logic [31:0] v;
    wr(STAT, 32'hFFFF_FFFF);
    rd(STAT, v); check("R9 status write ignored", v, 32'd1);
  endtask

  task automatic t_load();
    logic [31:0] v;
    wr(UDVS, 32'd3);
    wr(UDVD, 32'd99);
    repeat (5) @(negedge clk);
    wr(QUO, 32'h0000_1234);
    rd(STAT, v); check("R8 ready after load", v[0], 32'd1);
    wr(REMA, 32'h0000_0ABC);
    repeat (40) @(negedge clk);
    rd(QUO, v);  check("R8 quotient kept", v, 32'h0000_1234);
    rd(REMA, v); check("R8 remainder kept", v, 32'h0000_0ABC);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_timing();
    t_restart();
    t_unsigned();
    t_signed();
    t_divzero();
    t_map();
    t_dirty();
    t_csr_ro();
    t_load();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule